// File: doc/BRIEF.md
# GPIO Bank Output Data Path

This block is one 32-channel general-purpose I/O bank with an APB slave port. Software sets the level each pin drives, chooses per pin whether it is an input or an output, and chooses whether an output actually drives its pad. The drive level can be changed in three ways. One full-width write replaces all 32 bits. Two masked half-word writes each change only the selected bits of one half, so software never has to read, modify and write back.

Readback keeps two views apart. The drive-level registers return what software last wrote. A separate read-only register returns the pad levels after a two-stage synchronizer. A per-pin master tristate input from outside the bank can force any pad off. Synchronized levels of the pins set as inputs go out on a detector feed for interrupt logic placed elsewhere.

Top module: `pinbank_apb`

## Requirements
- R1: After reset every register is 0, so `pad_out`, `pad_oe` and `det_in` are all 0 and reads of the level, direction and enable registers return 0.
- R2: A write to the level register at byte offset 0x00 replaces all 32 drive bits, and `pad_out` shows the new value in the cycle after the APB access phase.
- R3: A write to offset 0x04 treats bits [31:16] of the write data as a mask and bits [15:0] as data for channels 0 to 15. Where a mask bit is 0 the matching channel takes the data bit. Where it is 1 the channel keeps its old level. Channels 16 to 31 do not change.
- R4: A write to offset 0x08 uses the same mask/data layout for channels 16 to 31. Data bit k goes to channel 16+k. Channels 0 to 15 do not change.
- R5: Reads at 0x00, 0x04 and 0x08 all return the current drive-level register, whichever of the three paths last wrote it, and never the pad level. Every transfer completes with `pready` high.
- R6: The read-only register at 0x14 returns the pad inputs after two clock edges of synchronization, for every pin, whatever its direction and drive level.
- R7: The direction register (0x0C, 1 = output) and the enable register (0x10, 1 = drive) are read/write. A pad is driven (`pad_oe` bit 1) only when its direction bit and its enable bit are both 1.
- R8: A 1 on a bit of `mst_tri` forces the matching `pad_oe` bit to 0, whatever the enable bit holds. The effect is combinational.
- R9: `det_in` carries the synchronized pad level for pins whose direction bit is 0, and 0 for output pins.
- R10: Writes to the read-only offset, writes to unmapped or misaligned addresses, and a setup phase without `penable` change no register. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pad_in | input | N_CHAN | Raw pad input levels |
| mst_tri | input | N_CHAN | Per-pin master tristate force |
| pad_out | output | N_CHAN | Per-pin drive level |
| pad_oe | output | N_CHAN | Per-pin output enable |
| det_in | output | N_CHAN | Synchronized input levels for an interrupt detector |

## Verification
The bench builds the block with its default parameters: 32 channels, an 8-bit address and two synchronizer stages. With the 8-bit address, offset 0x40 is an unmapped word and can be used to show that writes there are dropped and reads there return zero. With exactly two synchronizer stages, `det_in` can be checked one edge after a pad change (still the old level) and two edges after it (the new level). That pins down the latency of the input path.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

   // Width of one masked-write half and of the bus word
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned HALF_W = BUS_W / 2;

   // Word indices (byte offset / 4) of the register file
   localparam int unsigned WIX_LEVEL = 0;
   localparam int unsigned WIX_MLO   = 1;
   localparam int unsigned WIX_MHI   = 2;
   localparam int unsigned WIX_DIR   = 3;
   localparam int unsigned WIX_OE    = 4;
   localparam int unsigned WIX_PIN   = 5;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_LEVEL,
      RS_MLO,
      RS_MHI,
      RS_DIR,
      RS_OE,
      RS_PIN
   } regsel_e;

   // Masked merge: mask bit 1 keeps the old bit, 0 takes the new data bit
   function automatic logic [HALF_W-1:0] merge_half(
      input logic [HALF_W-1:0] old_bits,
      input logic [BUS_W-1:0]  word
   );
      logic [HALF_W-1:0] keep;
      keep = word[BUS_W-1:HALF_W];
      return (old_bits & keep) | (word[HALF_W-1:0] & ~keep);
   endfunction

endpackage

// File: rtl/pinbank_dec.sv
module pinbank_dec
   import pinbank_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output regsel_e           sel,
   output logic              wr_stb
);

   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             aligned;

   assign idx     = paddr[ADDR_W-1:2];
   assign aligned = (paddr[1:0] == 2'b00);

   always_comb begin
      sel = RS_NONE;
      if (aligned) begin
         case (idx)
            IDX_W'(WIX_LEVEL): sel = RS_LEVEL;
            IDX_W'(WIX_MLO):   sel = RS_MLO;
            IDX_W'(WIX_MHI):   sel = RS_MHI;
            IDX_W'(WIX_DIR):   sel = RS_DIR;
            IDX_W'(WIX_OE):    sel = RS_OE;
            IDX_W'(WIX_PIN):   sel = RS_PIN;
            default:           sel = RS_NONE;
         endcase
      end
   end

   // Register update happens only in the access phase of a write
   assign wr_stb = psel & penable & pwrite;

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
   import pinbank_pkg::*;
#(
   parameter int N_CHAN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  regsel_e           sel,
   input  logic [BUS_W-1:0]  wdata,
   output logic [N_CHAN-1:0] level_q,
   output logic [N_CHAN-1:0] dir_q,
   output logic [N_CHAN-1:0] oe_q
);

   localparam int N_HALF = N_CHAN / HALF_W;

   logic [N_CHAN-1:0] merged;
   logic [N_CHAN-1:0] level_d;
   logic [N_CHAN-1:0] dir_d;
   logic [N_CHAN-1:0] oe_d;

   // One merge unit per half; both see the same mask/data word
   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      assign merged[h*HALF_W +: HALF_W] =
         merge_half(level_q[h*HALF_W +: HALF_W], wdata);
   end

   always_comb begin
      level_d = level_q;
      dir_d   = dir_q;
      oe_d    = oe_q;
      if (wr_stb) begin
         case (sel)
            RS_LEVEL: level_d = wdata[N_CHAN-1:0];
            RS_MLO:   level_d[HALF_W-1:0]      = merged[HALF_W-1:0];
            RS_MHI:   level_d[N_CHAN-1:HALF_W] = merged[N_CHAN-1:HALF_W];
            RS_DIR:   dir_d = wdata[N_CHAN-1:0];
            RS_OE:    oe_d  = wdata[N_CHAN-1:0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         dir_q   <= '0;
         oe_q    <= '0;
      end else begin
         level_q <= level_d;
         dir_q   <= dir_d;
         oe_q    <= oe_d;
      end
   end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/pinbank_pad.sv
module pinbank_pad #(
   parameter int N_CHAN = 32
) (
   input  logic [N_CHAN-1:0] level_q,
   input  logic [N_CHAN-1:0] dir_q,
   input  logic [N_CHAN-1:0] oe_q,
   input  logic [N_CHAN-1:0] mst_tri,
   input  logic [N_CHAN-1:0] pin_q,
   output logic [N_CHAN-1:0] pad_out,
   output logic [N_CHAN-1:0] pad_oe,
   output logic [N_CHAN-1:0] det_in
);

   for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
      logic drive_req;
      assign drive_req  = dir_q[i] & oe_q[i];
      assign pad_out[i] = level_q[i];
      assign pad_oe[i]  = drive_req & ~mst_tri[i];
      assign det_in[i]  = pin_q[i] & ~dir_q[i];
   end

endmodule

// File: rtl/pinbank_apb.sv
module pinbank_apb
   import pinbank_pkg::*;
#(
   parameter int N_CHAN      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   input  logic [N_CHAN-1:0] pad_in,
   input  logic [N_CHAN-1:0] mst_tri,
   output logic [N_CHAN-1:0] pad_out,
   output logic [N_CHAN-1:0] pad_oe,
   output logic [N_CHAN-1:0] det_in
);

   // Elaboration-time parameter checks
   if (N_CHAN != BUS_W) begin : g_bad_chan
      $error("pinbank_apb: N_CHAN must equal the 32-bit bus width");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("pinbank_apb: ADDR_W must cover offsets up to 0x14");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pinbank_apb: SYNC_STAGES must be at least 2");
   end

   regsel_e           sel;
   logic              wr_stb;
   logic [N_CHAN-1:0] level_q;
   logic [N_CHAN-1:0] dir_q;
   logic [N_CHAN-1:0] oe_q;
   logic [N_CHAN-1:0] pin_q;

   pinbank_dec #(.ADDR_W(ADDR_W)) u_dec (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .sel     (sel),
      .wr_stb  (wr_stb)
   );

   pinbank_regs #(.N_CHAN(N_CHAN)) u_regs (
      .clk     (pclk),
      .rst_n   (presetn),
      .wr_stb  (wr_stb),
      .sel     (sel),
      .wdata   (pwdata),
      .level_q (level_q),
      .dir_q   (dir_q),
      .oe_q    (oe_q)
   );

   pinbank_sync #(.WIDTH(N_CHAN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (pclk),
      .rst_n (presetn),
      .din   (pad_in),
      .dout  (pin_q)
   );

   pinbank_pad #(.N_CHAN(N_CHAN)) u_pad (
      .level_q (level_q),
      .dir_q   (dir_q),
      .oe_q    (oe_q),
      .mst_tri (mst_tri),
      .pin_q   (pin_q),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .det_in  (det_in)
   );

   // Zero-wait-state read mux
   always_comb begin
      prdata = '0;
      if (psel && !pwrite) begin
         case (sel)
            RS_LEVEL, RS_MLO, RS_MHI: prdata = level_q;
            RS_DIR:                   prdata = dir_q;
            RS_OE:                    prdata = oe_q;
            RS_PIN:                   prdata = pin_q;
            default:                  prdata = '0;
         endcase
      end
   end

   assign pready = 1'b1;

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
   import pinbank_pkg::*;
#(
   parameter int N_CHAN = 32,
   parameter int ADDR_W = 8
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [N_CHAN-1:0] mst_tri,
   input logic [N_CHAN-1:0] pad_out,
   input logic [N_CHAN-1:0] pad_oe,
   input logic [N_CHAN-1:0] dir_q,
   input logic [N_CHAN-1:0] oe_q
);

   logic wr_any;
   logic wr_lo;
   logic wr_hi;

   assign wr_any = psel & penable & pwrite;
   assign wr_lo  = wr_any && (paddr == ADDR_W'(WIX_MLO * 4));
   assign wr_hi  = wr_any && (paddr == ADDR_W'(WIX_MHI * 4));

   // R1: while reset is held, nothing is driven
   always @(posedge pclk) begin
      if (!presetn) begin
         assert_reset_idle_R1: assert (pad_oe == '0 && pad_out == '0)
            else $error("R1: outputs not idle in reset");
      end
   end

   // R3: low masked write leaves the upper half untouched
   assert_lo_keeps_hi_R3: assert property (@(posedge pclk) disable iff (!presetn)
      wr_lo |=> pad_out[N_CHAN-1:HALF_W] == $past(pad_out[N_CHAN-1:HALF_W]));

   // R4: high masked write leaves the lower half untouched
   assert_hi_keeps_lo_R4: assert property (@(posedge pclk) disable iff (!presetn)
      wr_hi |=> pad_out[HALF_W-1:0] == $past(pad_out[HALF_W-1:0]));

   // R7: a driven pad needs both its direction and enable bits set
   assert_oe_gate_R7: assert property (@(posedge pclk) disable iff (!presetn)
      (pad_oe & ~(dir_q & oe_q)) == '0);

   // R8: master tristate always wins
   assert_tri_force_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (pad_oe & mst_tri) == '0);

   // R10: without a write access the drive levels hold
   assert_idle_hold_R10: assert property (@(posedge pclk) disable iff (!presetn)
      !wr_any |=> $stable(pad_out));

endmodule

bind pinbank_apb pinbank_chk #(.N_CHAN(N_CHAN), .ADDR_W(ADDR_W)) u_chk (
   .pclk    (pclk),
   .presetn (presetn),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .mst_tri (mst_tri),
   .pad_out (pad_out),
   .pad_oe  (pad_oe),
   .dir_q   (dir_q),
   .oe_q    (oe_q)
);

// File: tb/pinbank_apb_test.sv
`timescale 1ns/1ps
module pinbank_apb_test;

   localparam int NC = 32;
   localparam int AW = 8;

   localparam logic [AW-1:0] A_LEVEL = 8'h00;
   localparam logic [AW-1:0] A_MLO   = 8'h04;
   localparam logic [AW-1:0] A_MHI   = 8'h08;
   localparam logic [AW-1:0] A_DIR   = 8'h0C;
   localparam logic [AW-1:0] A_OE    = 8'h10;
   localparam logic [AW-1:0] A_PIN   = 8'h14;
   localparam logic [AW-1:0] A_HOLE  = 8'h40;

   logic          pclk = 1'b0;
   logic          presetn = 1'b1;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic          pready;
   logic [NC-1:0] pad_in = '0, mst_tri = '0;
   logic [NC-1:0] pad_out, pad_oe, det_in;

   int n_run  = 0;
   int n_fail = 0;

   logic [31:0] q_val[$];
   string       q_tag[$];

   // Bench model of the registers
   logic [31:0] m_level = '0, m_dir = '0, m_oe = '0;

   always #2 pclk = ~pclk;   // 250 MHz

   pinbank_apb #(.N_CHAN(NC), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pad_in(pad_in), .mst_tri(mst_tri),
      .pad_out(pad_out), .pad_oe(pad_oe), .det_in(det_in)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] merge_model(input logic [31:0] old, input logic [31:0] w, input bit hi);
      logic [15:0] o, n;
      o = hi ? old[31:16] : old[15:0];
      for (int k = 0; k < 16; k++) n[k] = w[16+k] ? o[k] : w[k];
      return hi ? {n, old[15:0]} : {old[31:16], n};
   endfunction

   task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      q_val.push_back(exp);
      q_tag.push_back(tag);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   // Monitor: samples the access phase 1 ns after the falling edge
   always begin
      @(negedge pclk);
      #1;
      if (psel && penable && !pwrite) begin
         if (q_val.size() == 0) begin
            check("R5 unexpected read", prdata, 32'hx);
         end else begin
            automatic logic [31:0] e = q_val.pop_front();
            automatic string       t = q_tag.pop_front();
            check(t, prdata, e);
            check({t, " pready R5"}, {31'b0, pready}, 32'd1);
         end
      end
   end

   initial begin
      #400000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] p;
      #1 presetn = 1'b0;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;

      // R1 reset state
      @(negedge pclk); #1;
      check("R1 pad_out", pad_out, 32'h0);
      check("R1 pad_oe", pad_oe, 32'h0);
      check("R1 det_in", det_in, 32'h0);
      apb_rd(A_LEVEL, 32'h0, "R1 level");
      apb_rd(A_DIR, 32'h0, "R1 dir");
      apb_rd(A_OE, 32'h0, "R1 oe");

      // R2 full writes
      apb_wr(A_LEVEL, 32'hFFFF_FFFF); m_level = 32'hFFFF_FFFF;
      check("R2 pad_out ones", pad_out, m_level);
      apb_wr(A_LEVEL, 32'hA5A5_5A5A); m_level = 32'hA5A5_5A5A;
      check("R2 pad_out pattern", pad_out, m_level);
      apb_rd(A_LEVEL, m_level, "R2 R5 level readback");

      // R3 low masked write
      apb_wr(A_MLO, {16'hFF00, 16'h1234}); m_level = merge_model(m_level, {16'hFF00, 16'h1234}, 1'b0);
      check("R3 pad_out", pad_out, m_level);
      check("R3 literal", pad_out, 32'hA5A5_5A34);
      apb_wr(A_MLO, {16'hFFFF, 16'h0000});
      check("R3 full mask keeps", pad_out, m_level);
      apb_rd(A_MLO, m_level, "R3 R5 mlo readback");

      // R4 high masked write
      apb_wr(A_MHI, {16'h00F0, 16'hBEEF}); m_level = merge_model(m_level, {16'h00F0, 16'hBEEF}, 1'b1);
      check("R4 pad_out", pad_out, m_level);
      check("R4 literal", pad_out, 32'hBEAF_5A34);
      apb_rd(A_MHI, m_level, "R4 R5 mhi readback");
      apb_rd(A_LEVEL, m_level, "R5 level after masked");

      // R7 direction and enable
      apb_wr(A_DIR, 32'hFFFF_0000); m_dir = 32'hFFFF_0000;
      apb_wr(A_OE, 32'hFF00_FF00);  m_oe  = 32'hFF00_FF00;
      check("R7 pad_oe", pad_oe, m_dir & m_oe);
      apb_rd(A_DIR, m_dir, "R7 dir readback");
      apb_rd(A_OE, m_oe, "R7 oe readback");

      // R8 master tristate
      @(negedge pclk); mst_tri = 32'h0F00_0000; #1;
      check("R8 partial force", pad_oe, 32'hF000_0000);
      @(negedge pclk); mst_tri = 32'hFFFF_FFFF; #1;
      check("R8 full force", pad_oe, 32'h0);
      @(negedge pclk); mst_tri = 32'h0; #1;
      check("R8 release", pad_oe, 32'hFF00_0000);

      // R6 and R9 synchronizer latency and detector feed
      p = 32'h1357_2468;
      @(negedge pclk); pad_in = p;
      @(negedge pclk); #1;
      check("R6 one edge still old", det_in, 32'h0);
      @(negedge pclk); #1;
      check("R6 R9 det_in after two edges", det_in, p & ~m_dir);
      apb_rd(A_PIN, p, "R6 pin readback");
      apb_rd(A_LEVEL, m_level, "R5 level is not pin");

      // R10 ignored accesses
      apb_wr(A_PIN, 32'hFFFF_FFFF);
      apb_wr(A_HOLE, 32'h1234_5678);
      apb_wr(A_DIR + 8'h1, 32'h0000_0000);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = A_LEVEL; pwdata = 32'h0;
      @(negedge pclk);
      psel = 1'b0; pwrite = 1'b0;
      #1;
      check("R10 pad_out held", pad_out, m_level);
      apb_rd(A_LEVEL, m_level, "R10 level held");
      apb_rd(A_DIR, m_dir, "R10 dir held");
      apb_rd(A_HOLE, 32'h0, "R10 unmapped read");
      apb_rd(A_PIN, p, "R10 pin held");

      repeat (2) @(negedge pclk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule